// File: doc/BRIEF.md
# Host-to-Controller Command Mailbox

This block is the register window a host processor uses to hand commands to a management microcontroller and collect results. The host sees a 32-bit register bus with an 8-bit byte address. It can load two pointer words and up to four payload words, then post a packed command word. Writing that word is the doorbell. The block sets busy, latches the command and pulses an interrupt toward the responder.

On the responder side, firmware or a command engine reads the latched command, the pointers and the payload words. It fills a four-word result buffer and signals done with an error flag and an 8-bit error code. The host either polls the busy bit or, when the command asked for it, receives a one-cycle completion interrupt backed by a sticky flag that it acknowledges in the status register.

Top module: `mbx_regs`

## Requirements
- R1: After reset, the status word reads 0, `h_rdata` is 0, and both interrupt outputs are low.
- R2: A full-word write to offset 0x00 while idle is accepted:
  - the status word then shows busy (bit 0) set, error (bit 1) clear, the error code (bits 31:24) cleared, bits 15:12 of the command in bits 15:12, and `h_init_id` in bits 23:16;
  - `resp_cmd` carries the written word;
  - `resp_irq` is high for exactly the cycle after the write.
- R3: A command write while busy is dropped:
  - `resp_cmd` is unchanged and `resp_irq` stays low;
  - overrun (status bit 3) sets and stays set until a status write with bit 3 set clears it.
- R4: When `resp_done` is sampled high while busy, busy clears on that edge. Status bit 1 takes `resp_err` and bits 31:24 take `resp_code`.
- R5: If bit 8 of the accepted command was set, completion pulses `host_irq` for one cycle and sets status bit 2. Otherwise neither happens. Status bit 2 clears only on a status write with bit 2 set.
- R6: Full-word writes to offsets 0x08 and 0x0C load the source and destination pointers. These read back at the same offsets and drive `resp_sptr` and `resp_dptr`.
- R7: Full-word writes to 0x80 + 4k load payload word k. The responder reads it on `resp_wb_data` one cycle after presenting k on `resp_wb_idx`. Host writes with `h_byte` set are ignored everywhere.
- R8: The responder writes result word k with `resp_rb_we`. A host word read at 0x90 + 4k returns it. A byte read returns byte `h_addr[1:0]` (0 = least significant) in bits 7:0, with the upper bits zero.
- R9: Host reads of the command offset, the payload buffer and any unmapped offset return 0.
- R10: `resp_done` while idle changes no status field and raises no host interrupt.
- R11: `h_rdata` updates on the clock edge that samples `h_rd` and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_byte | input | 1 | Host access is a single byte |
| h_addr | input | 8 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_init_id | input | 8 | Initiator id of the host issuing the access |
| h_rdata | output | 32 | Host read data, one cycle after `h_rd` |
| host_irq | output | 1 | One-cycle completion interrupt to the host |
| resp_irq | output | 1 | One-cycle command-posted interrupt to the responder |
| resp_cmd | output | 32 | Latched command word |
| resp_sptr | output | 32 | Source pointer |
| resp_dptr | output | 32 | Destination pointer |
| resp_wb_idx | input | 2 | Payload word index |
| resp_wb_data | output | 32 | Payload word, registered |
| resp_rb_we | input | 1 | Result buffer write enable |
| resp_rb_idx | input | 2 | Result word index |
| resp_rb_data | input | 32 | Result word to store |
| resp_done | input | 1 | Responder completion strobe |
| resp_err | input | 1 | Error flag reported with completion |
| resp_code | input | 8 | Error code reported with completion |

## Verification
The assertions assume the host never raises `h_wr` and `h_rd` together. They also assume the responder pulses `resp_done` for a single cycle per command. The stimulus drives one host access or one responder strobe at a time, each lasting one clock. Random command words, initiator ids, error codes and result data are mixed with directed cases. These cover a post while busy, completion while idle, ignored byte writes and every byte lane of the result buffer.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW    = 32;
  localparam int BUF_N = 4;
  localparam int BUF_IW = $clog2(BUF_N);

  // status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_FLAG = 2;
  localparam int ST_OVR  = 3;
  // command word: completion-interrupt request bit
  localparam int CMD_IOC = 8;

  typedef enum logic [2:0] {
    RG_NONE, RG_CMD, RG_STAT, RG_SPTR, RG_DPTR, RG_WBUF, RG_RBUF
  } mbx_reg_e;

  // decode on the word address (byte address bits 7:2)
  function automatic mbx_reg_e mbx_decode(input logic [5:0] wa);
    mbx_reg_e r;
    r = RG_NONE;
    if (wa[5:2] == 4'h8)      r = RG_WBUF;
    else if (wa[5:2] == 4'h9) r = RG_RBUF;
    else if (wa[5:2] == 4'h0) begin
      case (wa[1:0])
        2'd0:    r = RG_CMD;
        2'd1:    r = RG_STAT;
        2'd2:    r = RG_SPTR;
        default: r = RG_DPTR;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/mbx_buf.sv
module mbx_buf #(
  parameter int WORDS  = 4,
  parameter int WIDTH  = 32,
  parameter bit REG_RD = 1'b0,
  localparam int IW    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IW-1:0]    wa,
  input  logic [WIDTH-1:0] wd,
  input  logic [IW-1:0]    ra,
  output logic [WIDTH-1:0] rd
);
  logic [WIDTH-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  generate
    if (REG_RD) begin : g_sync
      logic [WIDTH-1:0] rd_q;
      always_ff @(posedge clk) rd_q <= mem[ra];
      assign rd = rd_q;
    end else begin : g_async
      assign rd = mem[ra];
    end
  endgenerate
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr,
  input  logic [DW-1:0] cmd_wd,
  input  logic [7:0]    init_id,
  input  logic          stat_wr,
  input  logic [1:0]    stat_clr,   // [0] ack completion flag, [1] clear overrun
  input  logic          done,
  input  logic          done_err,
  input  logic [7:0]    done_code,
  output logic [DW-1:0] status,
  output logic [DW-1:0] cmd_q,
  output logic          resp_irq,
  output logic          host_irq
);
  logic       busy_q, err_q, flag_q, ovr_q;
  logic [7:0] init_q, code_q;
  logic       accept, fin;

  assign accept = cmd_wr & ~busy_q;
  assign fin    = done & busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0; err_q <= 1'b0; flag_q <= 1'b0; ovr_q <= 1'b0;
      init_q <= '0; code_q <= '0; cmd_q <= '0;
      resp_irq <= 1'b0; host_irq <= 1'b0;
    end else begin
      resp_irq <= accept;
      host_irq <= fin & cmd_q[CMD_IOC];
      if (accept) begin
        busy_q <= 1'b1;
        cmd_q  <= cmd_wd;
        init_q <= init_id;
        err_q  <= 1'b0;
        code_q <= '0;
      end else if (fin) begin
        busy_q <= 1'b0;
        err_q  <= done_err;
        code_q <= done_code;
      end
      if (cmd_wr & busy_q)             ovr_q <= 1'b1;
      else if (stat_wr & stat_clr[1])  ovr_q <= 1'b0;
      if (fin & cmd_q[CMD_IOC])        flag_q <= 1'b1;
      else if (stat_wr & stat_clr[0])  flag_q <= 1'b0;
    end
  end

  assign status = {code_q, init_q, cmd_q[15:12], 8'h00, ovr_q, flag_q, err_q, busy_q};

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && !busy_q |=> busy_q && resp_irq); // R2
  AST_DROP_BUSY_WR: assert property (@(posedge clk) disable iff (rst)
    cmd_wr && busy_q |=> ovr_q && $stable(cmd_q) && !resp_irq); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    done && busy_q |=> !busy_q); // R4
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> flag_q); // R5
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (rst)
    !busy_q |=> !host_irq); // R10
endmodule

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic              h_byte,
  input  logic [7:0]        h_addr,
  input  logic [DW-1:0]     h_wdata,
  input  logic [7:0]        h_init_id,
  output logic [DW-1:0]     h_rdata,
  output logic              host_irq,
  output logic              resp_irq,
  output logic [DW-1:0]     resp_cmd,
  output logic [DW-1:0]     resp_sptr,
  output logic [DW-1:0]     resp_dptr,
  input  logic [BUF_IW-1:0] resp_wb_idx,
  output logic [DW-1:0]     resp_wb_data,
  input  logic              resp_rb_we,
  input  logic [BUF_IW-1:0] resp_rb_idx,
  input  logic [DW-1:0]     resp_rb_data,
  input  logic              resp_done,
  input  logic              resp_err,
  input  logic [7:0]        resp_code
);
  mbx_reg_e      sel;
  logic          wword;
  logic [DW-1:0] status, rb_word, rword, rsel;
  logic [DW-1:0] sptr_q, dptr_q;

  assign sel   = mbx_decode(h_addr[7:2]);
  assign wword = h_wr & ~h_byte;

  mbx_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cmd_wr(wword && sel == RG_CMD), .cmd_wd(h_wdata), .init_id(h_init_id),
    .stat_wr(wword && sel == RG_STAT), .stat_clr({h_wdata[ST_OVR], h_wdata[ST_FLAG]}),
    .done(resp_done), .done_err(resp_err), .done_code(resp_code),
    .status(status), .cmd_q(resp_cmd), .resp_irq(resp_irq), .host_irq(host_irq)
  );

  mbx_buf #(.WORDS(BUF_N), .WIDTH(DW), .REG_RD(1'b1)) u_wbuf (
    .clk(clk), .we(wword && sel == RG_WBUF), .wa(h_addr[3:2]), .wd(h_wdata),
    .ra(resp_wb_idx), .rd(resp_wb_data)
  );

  mbx_buf #(.WORDS(BUF_N), .WIDTH(DW), .REG_RD(1'b0)) u_rbuf (
    .clk(clk), .we(resp_rb_we), .wa(resp_rb_idx), .wd(resp_rb_data),
    .ra(h_addr[3:2]), .rd(rb_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sptr_q <= '0;
      dptr_q <= '0;
    end else begin
      if (wword && sel == RG_SPTR) sptr_q <= h_wdata;
      if (wword && sel == RG_DPTR) dptr_q <= h_wdata;
    end
  end
  assign resp_sptr = sptr_q;
  assign resp_dptr = dptr_q;

  always_comb begin
    case (sel)
      RG_STAT: rword = status;
      RG_SPTR: rword = sptr_q;
      RG_DPTR: rword = dptr_q;
      RG_RBUF: rword = rb_word;
      default: rword = '0;
    endcase
    rsel = h_byte ? {24'h0, 8'(rword >> {h_addr[1:0], 3'b000})} : rword;
  end

  always_ff @(posedge clk) begin
    if (rst)       h_rdata <= '0;
    else if (h_rd) h_rdata <= rsel;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    h_rd && (sel == RG_NONE || sel == RG_CMD || sel == RG_WBUF) |=> h_rdata == '0); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !h_rd |=> $stable(h_rdata)); // R11
endmodule

// File: tb/sim_mbx_regs.sv
`timescale 1ns/1ps
module sim_mbx_regs;
  logic        clk = 1'b0;
  logic        rst, h_wr, h_rd, h_byte;
  logic [7:0]  h_addr, h_init_id, resp_code;
  logic [31:0] h_wdata, h_rdata, resp_cmd, resp_sptr, resp_dptr, resp_wb_data, resp_rb_data;
  logic        host_irq, resp_irq, resp_rb_we, resp_done, resp_err;
  logic [1:0]  resp_wb_idx, resp_rb_idx;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rb_m [4];
  logic [31:0] wb_m [4];

  always #10 clk = ~clk;

  mbx_regs u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_st(input logic busy, err, flag, ovr,
      input logic [3:0] sub, input logic [7:0] init, code);
    return {code, init, sub, 8'h00, ovr, flag, err, busy};
  endfunction

  task automatic hw(input logic [7:0] a, input logic [31:0] d, input logic b);
    @(negedge clk); h_wr = 1; h_addr = a; h_wdata = d; h_byte = b;
    @(negedge clk); h_wr = 0; h_byte = 0;
  endtask

  task automatic hr(input logic [7:0] a, input logic b, output logic [31:0] d);
    @(negedge clk); h_rd = 1; h_addr = a; h_byte = b;
    @(negedge clk); h_rd = 0; h_byte = 0; d = h_rdata;
  endtask

  task automatic post(input logic [31:0] c, input logic [7:0] id, input logic expect_pulse);
    h_init_id = id;
    hw(8'h00, c, 1'b0);
    chk(expect_pulse ? "R2 resp_irq pulse" : "R3 no resp_irq", {31'b0, resp_irq}, {31'b0, expect_pulse});
    @(negedge clk);
    chk("R2 resp_irq one cycle", {31'b0, resp_irq}, 32'h0);
  endtask

  task automatic finish_cmd(input logic e, input logic [7:0] c, output logic hi);
    @(negedge clk); resp_done = 1; resp_err = e; resp_code = c;
    @(negedge clk); resp_done = 0; hi = host_irq;
    @(negedge clk);
    chk("R5 host_irq one cycle", {31'b0, host_irq}, 32'h0);
  endtask

  task automatic rb_fill(input logic [1:0] k, input logic [31:0] d);
    @(negedge clk); resp_rb_we = 1; resp_rb_idx = k; resp_rb_data = d;
    @(negedge clk); resp_rb_we = 0;
    rb_m[k] = d;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d, c;
    logic [7:0]  id, code;
    logic        hi, e, ioc, ovr;
    void'($urandom(32'd4242));
    rst = 1; h_wr = 0; h_rd = 0; h_byte = 0; h_addr = 0; h_wdata = 0; h_init_id = 0;
    resp_wb_idx = 0; resp_rb_we = 0; resp_rb_idx = 0; resp_rb_data = 0;
    resp_done = 0; resp_err = 0; resp_code = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 h_rdata", h_rdata, 32'h0);
    chk("R1 irqs", {30'b0, host_irq, resp_irq}, 32'h0);
    hr(8'h04, 0, d); chk("R1 status", d, 32'h0);
    for (int k = 0; k < 4; k++) rb_fill(k[1:0], 32'h0);

    // R6 pointers
    hw(8'h08, 32'hA5A5_0108, 0); hw(8'h0C, 32'h5A5A_020C, 0);
    hr(8'h08, 0, d); chk("R6 sptr read", d, 32'hA5A5_0108);
    hr(8'h0C, 0, d); chk("R6 dptr read", d, 32'h5A5A_020C);
    chk("R6 resp_sptr", resp_sptr, 32'hA5A5_0108);
    chk("R6 resp_dptr", resp_dptr, 32'h5A5A_020C);
    hw(8'h08, 32'hFFFF_FFFF, 1);
    hr(8'h08, 0, d); chk("R7 byte write ignored on pointer", d, 32'hA5A5_0108);

    // R7 payload buffer
    for (int k = 0; k < 4; k++) begin
      wb_m[k] = $urandom;
      hw(8'h80 + 8'(4 * k), wb_m[k], 0);
    end
    hw(8'h85, 32'hDEAD_BEEF, 1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); resp_wb_idx = k[1:0];
      @(negedge clk); chk("R7 payload word", resp_wb_data, wb_m[k]);
    end
    hr(8'h84, 0, d); chk("R9 payload not readable", d, 32'h0);
    hr(8'h00, 0, d); chk("R9 command not readable", d, 32'h0);
    hr(8'h40, 0, d); chk("R9 unmapped", d, 32'h0);

    // directed: post without completion irq, overrun, error completion
    post(32'hFF00_30F1, 8'h11, 1);
    chk("R2 resp_cmd", resp_cmd, 32'hFF00_30F1);
    hr(8'h04, 0, d); chk("R2 status busy", d, exp_st(1, 0, 0, 0, 4'h3, 8'h11, 8'h00));
    post(32'h0000_5123, 8'h22, 0);
    chk("R3 resp_cmd unchanged", resp_cmd, 32'hFF00_30F1);
    hr(8'h04, 0, d); chk("R3 overrun set", d, exp_st(1, 0, 0, 1, 4'h3, 8'h11, 8'h00));
    finish_cmd(1, 8'h5A, hi);
    chk("R5 no irq without request", {31'b0, hi}, 32'h0);
    hr(8'h04, 0, d); chk("R4 error done", d, exp_st(0, 1, 0, 1, 4'h3, 8'h11, 8'h5A));
    hw(8'h04, 32'h0000_0004, 0);
    hr(8'h04, 0, d); chk("R3 overrun sticky", d, exp_st(0, 1, 0, 1, 4'h3, 8'h11, 8'h5A));
    hw(8'h04, 32'h0000_0008, 0);
    hr(8'h04, 0, d); chk("R3 overrun cleared", d, exp_st(0, 1, 0, 0, 4'h3, 8'h11, 8'h5A));
    // R10 done while idle
    finish_cmd(0, 8'h77, hi);
    chk("R10 no host irq", {31'b0, hi}, 32'h0);
    hr(8'h04, 0, d); chk("R10 status unchanged", d, exp_st(0, 1, 0, 0, 4'h3, 8'h11, 8'h5A));
    // R11 hold
    repeat (3) @(negedge clk);
    chk("R11 rdata held", h_rdata, exp_st(0, 1, 0, 0, 4'h3, 8'h11, 8'h5A));

    // random commands
    for (int it = 0; it < 40; it++) begin
      c = $urandom; id = 8'($urandom); ioc = c[8];
      post(c, id, 1);
      chk("R2 resp_cmd rnd", resp_cmd, c);
      hr(8'h04, 0, d); chk("R2 status rnd", d, exp_st(1, 0, 0, 0, c[15:12], id, 8'h00));
      ovr = 0;
      if (it % 7 == 3) begin
        post($urandom, 8'($urandom), 0);
        chk("R3 resp_cmd kept rnd", resp_cmd, c);
        ovr = 1;
      end
      for (int k = 0; k < 4; k++) if ($urandom % 2) rb_fill(k[1:0], $urandom);
      e = 1'($urandom); code = 8'($urandom);
      finish_cmd(e, code, hi);
      chk("R5 host_irq per request", {31'b0, hi}, {31'b0, ioc});
      hr(8'h04, 0, d); chk("R4 status rnd", d, exp_st(0, e, ioc, ovr, c[15:12], id, code));
      if (ioc) begin
        hw(8'h04, 32'h0000_0000, 0);
        hr(8'h04, 0, d); chk("R5 flag needs bit", d, exp_st(0, e, 1, ovr, c[15:12], id, code));
      end
      hw(8'h04, 32'h0000_000C, 0);
      hr(8'h04, 0, d); chk("R5 flag acked", d, exp_st(0, e, 0, 0, c[15:12], id, code));
      for (int k = 0; k < 4; k++) begin
        hr(8'h90 + 8'(4 * k), 0, d); chk("R8 result word", d, rb_m[k]);
      end
      begin
        logic [1:0] k = 2'($urandom), b = 2'($urandom);
        hr(8'h90 + 8'(4 * k) + 8'(b), 1, d);
        chk("R8 result byte", d, {24'h0, 8'(rb_m[k] >> (8 * b))});
      end
      hr(8'h10 + 8'(4 * ($urandom % 28)), 0, d); chk("R9 unmapped rnd", d, 32'h0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule